// File: doc/BRIEF.md
# Perfect Destination Address Filter with Setup-Frame Loading

This block decides, frame by frame, whether an incoming frame is addressed to this station. It keeps a table of sixteen 48-bit destination addresses and compares the destination address of each frame against all of them at once. A frame whose destination matches any entry is accepted. With the promiscuous input set, every frame is accepted.

The table is written by streaming in a fixed-format setup frame of 48 words, each 32 bits wide. Every address takes three consecutive words, and each word carries one 16-bit piece of the address in its low half. The words are collected in a staging copy. The live table changes only after a complete, correctly sized frame has arrived, so a truncated or overlong frame leaves the old table in use. Software normally fills unused slots with the station's own address and puts all ones in the last slot so that broadcast frames pass.

Top module: `setup_addr_filter`

## Requirements
- R1: After reset every table entry is zero and setupDone and acceptValid are low. A check of address 0 with promisc low is accepted, and a check of any nonzero address is rejected.
- R2: Setup word n, counting from 0, loads entry n/3, part n%3. Part 0 holds address bits 47:32, part 1 holds bits 31:16 and part 2 holds bits 15:0. Within a word, bits 7:0 carry the earlier byte, which goes to the upper byte of the part. Bits 15:8 carry the later byte. Bits 31:16 are ignored.
- R3: A setup stream of exactly 48 valid words, with setupLast on the 48th, replaces the whole table. setupDone is high for exactly one cycle, in the second cycle after the clock edge that takes the last word. From that cycle on, checks use the new table.
- R4: A setup stream that ends with setupLast on fewer than 48 words is discarded. The previous table stays in force and setupDone stays low.
- R5: A setup stream of more than 48 words before setupLast is discarded. The previous table stays in force and setupDone stays low.
- R6: A check whose address equals any of the 16 entries, including the first and the last slot, is accepted.
- R7: A check whose address equals no entry is rejected when promisc is low. This includes an address that differs from an entry only by byte order inside a 16-bit part.
- R8: While promisc is high, every checked address is accepted.
- R9: acceptValid is high in exactly the cycle after each cycle in which chkValid is high, and accept carries the decision in that cycle. When chkValid is low, acceptValid is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupValid | input | 1 | Setup word present on setupData |
| setupLast | input | 1 | Marks the final word of a setup stream |
| setupData | input | 32 | Setup word; only bits 15:0 are used |
| chkValid | input | 1 | Strobe requesting a decision for chkAddr |
| chkAddr | input | 48 | Destination address; bits 47:40 are the first byte on the wire |
| promisc | input | 1 | Accept every frame |
| accept | output | 1 | Decision; 1 means accept |
| acceptValid | output | 1 | accept is valid this cycle |
| setupDone | output | 1 | One-cycle pulse when a new table has taken effect |

## Verification
The hardest situation to reach is a rejected setup stream that must leave no trace. A stream one word short or one word long writes almost the whole staging copy but must never reach the live table. The bench loads one table and then streams a second, different table with 47 and then 49 words. Afterwards it confirms through ordinary checks that the first table's addresses still pass, that the second table's do not, and that setupDone never pulsed. It then sends a full 48-word frame of the second table to show that the staging copy recovers, and probes byte-swapped addresses to pin down the byte order within each word.

// File: rtl/setup_addr_filter_pkg.sv
package setup_addr_filter_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;    // write setup word into the staging slot selected by wordSel
    logic commit;  // copy staging table into live table
  } filtStrobes_t;
endpackage

// File: rtl/setup_addr_filter_ctrl.sv
module setup_addr_filter_ctrl
  import setup_addr_filter_pkg::*;
#(
  parameter int NUM_WORDS = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 setupValid,
  input  logic                 setupLast,
  output filtStrobes_t         strb,
  output logic [NUM_WORDS-1:0] wordSel,
  output logic                 setupDone
);
  localparam int CNT_W = $clog2(NUM_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_WORDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_WORDS - 1);

  logic [CNT_W-1:0] wordCnt;   // saturates at NUM_WORDS: further words ignored
  logic             commitPend;

  always_comb begin
    strb.wrEn   = setupValid && (wordCnt < CNT_FULL);
    strb.commit = commitPend;
    wordSel     = {{(NUM_WORDS-1){1'b0}}, 1'b1} << wordCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt    <= '0;
      commitPend <= 1'b0;
      setupDone  <= 1'b0;
    end else begin
      commitPend <= setupValid && setupLast && (wordCnt == CNT_LAST);
      setupDone  <= commitPend;
      if (setupValid) begin
        if (setupLast)
          wordCnt <= '0;
        else if (wordCnt != CNT_FULL)
          wordCnt <= wordCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/setup_addr_filter_dp.sv
module setup_addr_filter_dp
  import setup_addr_filter_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int WORD_W      = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  filtStrobes_t                         strb,
  input  logic [NUM_ENTRIES*3-1:0]             wordSel,
  input  logic [WORD_W-1:0]                    setupData,
  input  logic                                 chkValid,
  input  logic [47:0]                          chkAddr,
  input  logic                                 promisc,
  output logic                                 accept,
  output logic                                 acceptValid
);
  localparam int HALVES = 3;
  localparam int HALF_W = 16;
  localparam int ADDR_W = HALVES * HALF_W;

  logic [ADDR_W-1:0] stageQ [NUM_ENTRIES];
  logic [ADDR_W-1:0] tableQ [NUM_ENTRIES];
  logic [HALF_W-1:0] halfVal;
  logic [NUM_ENTRIES-1:0] hit;

  // earlier byte of the word (bits 7:0) becomes the upper byte of the part
  assign halfVal = {setupData[7:0], setupData[15:8]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        stageQ[e] <= '0;
        tableQ[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        for (int h = 0; h < HALVES; h++) begin
          if (strb.wrEn && wordSel[e*HALVES+h])
            stageQ[e][ADDR_W-1-h*HALF_W -: HALF_W] <= halfVal;
        end
        if (strb.commit)
          tableQ[e] <= stageQ[e];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : gen_cmp
      assign hit[g] = (tableQ[g] == chkAddr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accept      <= 1'b0;
      acceptValid <= 1'b0;
    end else begin
      acceptValid <= chkValid;
      accept      <= chkValid && (promisc || (|hit));
    end
  end
endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter
  import setup_addr_filter_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int WORD_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setupValid,
  input  logic              setupLast,
  input  logic [WORD_W-1:0] setupData,
  input  logic              chkValid,
  input  logic [47:0]       chkAddr,
  input  logic              promisc,
  output logic              accept,
  output logic              acceptValid,
  output logic              setupDone
);
  localparam int NUM_WORDS = NUM_ENTRIES * 3;

  filtStrobes_t         strb;
  logic [NUM_WORDS-1:0] wordSel;

  setup_addr_filter_ctrl #(.NUM_WORDS(NUM_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .setupValid(setupValid), .setupLast(setupLast),
    .strb(strb), .wordSel(wordSel), .setupDone(setupDone)
  );

  setup_addr_filter_dp #(.NUM_ENTRIES(NUM_ENTRIES), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wordSel(wordSel),
    .setupData(setupData), .chkValid(chkValid), .chkAddr(chkAddr),
    .promisc(promisc), .accept(accept), .acceptValid(acceptValid)
  );
endmodule

// File: rtl/setup_addr_filter_chk.sv
module setup_addr_filter_chk (
  input logic clk,
  input logic rstN,
  input logic setupValid,
  input logic setupLast,
  input logic chkValid,
  input logic promisc,
  input logic accept,
  input logic acceptValid,
  input logic setupDone
);
  AST_DECISION_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> acceptValid);                                        // R9
  AST_NO_SPURIOUS_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !acceptValid);                                      // R9
  AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && promisc) |=> accept);                                // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> !setupDone);                                        // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |-> $past(setupValid && setupLast, 2));                 // R3
  AST_ACCEPT_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> acceptValid);                                          // R9
endmodule

bind setup_addr_filter setup_addr_filter_chk chk_i (
  .clk(clk), .rstN(rstN), .setupValid(setupValid), .setupLast(setupLast),
  .chkValid(chkValid), .promisc(promisc), .accept(accept),
  .acceptValid(acceptValid), .setupDone(setupDone)
);

// File: tb/setup_addr_filter_tb.sv
module setup_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupValid = 1'b0;
  logic        setupLast = 1'b0;
  logic [31:0] setupData = '0;
  logic        chkValid = 1'b0;
  logic [47:0] chkAddr = '0;
  logic        promisc = 1'b0;
  logic        accept, acceptValid, setupDone;

  int nChecks = 0;
  int nFails  = 0;
  logic [47:0] tblA [16];
  logic [47:0] tblB [16];

  always #2.5 clk = ~clk;  // 200 MHz

  setup_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .setupValid(setupValid), .setupLast(setupLast),
    .setupData(setupData), .chkValid(chkValid), .chkAddr(chkAddr),
    .promisc(promisc), .accept(accept), .acceptValid(acceptValid),
    .setupDone(setupDone)
  );

  task automatic expect1(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] genAddr(input int s, input int e);
    logic [7:0] s8, e8;
    s8 = 8'(s);
    e8 = 8'(e);
    return {8'h02, s8, 8'(e*7+1), e8, 8'h5A ^ s8, e8 + s8 + 8'h10};
  endfunction

  function automatic logic [47:0] swapParts(input logic [47:0] a);
    return {a[39:32], a[47:40], a[23:16], a[31:24], a[7:0], a[15:8]};
  endfunction

  // One decision: strobe for one cycle, sample after the next edge
  task automatic doCheck(input logic [47:0] a, input logic pm, input logic expAcc, input string req);
    @(negedge clk);
    chkValid = 1'b1; chkAddr = a; promisc = pm;
    @(negedge clk);
    chkValid = 1'b0;
    expect1({req, " R9 valid"}, 64'(acceptValid), 64'd1);
    expect1(req, 64'(accept), 64'(expAcc));
    promisc = 1'b0;
  endtask

  // Stream nWords of table t; setupLast on the final word
  task automatic sendSetup(input logic [47:0] t[16], input int nWords, input logic expDone, input string req);
    for (int i = 0; i < nWords; i++) begin
      int e, h;
      logic [15:0] part;
      e = (i / 3) % 16;
      h = i % 3;
      part = t[e][47-16*h -: 16];
      @(negedge clk);
      setupValid = 1'b1;
      setupLast  = (i == nWords - 1);
      setupData  = {16'hA5C3, part[7:0], part[15:8]};
    end
    @(negedge clk);
    setupValid = 1'b0; setupLast = 1'b0; setupData = '0;
    expect1({req, " done early"}, 64'(setupDone), 64'd0);
    @(negedge clk);
    expect1({req, " done pulse"}, 64'(setupDone), 64'(expDone));
    @(negedge clk);
    expect1({req, " done one cycle"}, 64'(setupDone), 64'd0);
  endtask

  task automatic testReset();
    expect1("R1 setupDone", 64'(setupDone), 64'd0);
    expect1("R1 acceptValid", 64'(acceptValid), 64'd0);
    doCheck(48'h0, 1'b0, 1'b1, "R1 zero accepted");
    doCheck(48'h0000_0000_0001, 1'b0, 1'b0, "R1 nonzero rejected");
    @(negedge clk);
    expect1("R9 idle acceptValid", 64'(acceptValid), 64'd0);
  endtask

  task automatic testLoadA();
    sendSetup(tblA, 48, 1'b1, "R3 load A");
    for (int e = 0; e < 16; e++) doCheck(tblA[e], 1'b0, 1'b1, "R6 entry match");
    doCheck(48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, "R6 broadcast slot");
    doCheck(48'h0, 1'b0, 1'b0, "R3 old zero table replaced");
    doCheck(swapParts(tblA[0]), 1'b0, 1'b0, "R2 R7 byte order");
    doCheck(swapParts(tblA[7]), 1'b0, 1'b0, "R2 R7 byte order");
    doCheck(genAddr(9, 3), 1'b0, 1'b0, "R7 no match");
    doCheck(tblA[5] ^ 48'h1, 1'b0, 1'b0, "R7 one bit off");
  endtask

  task automatic testShort();
    sendSetup(tblB, 47, 1'b0, "R4 short stream");
    doCheck(tblA[0], 1'b0, 1'b1, "R4 old table kept");
    doCheck(tblA[14], 1'b0, 1'b1, "R4 old table kept");
    doCheck(tblB[0], 1'b0, 1'b0, "R4 new table absent");
  endtask

  task automatic testLong();
    sendSetup(tblB, 49, 1'b0, "R5 long stream");
    doCheck(tblA[1], 1'b0, 1'b1, "R5 old table kept");
    doCheck(tblB[1], 1'b0, 1'b0, "R5 new table absent");
  endtask

  task automatic testPromisc();
    doCheck(genAddr(77, 5), 1'b1, 1'b1, "R8 promisc accepts");
    doCheck(48'h1234_5678_9ABC, 1'b1, 1'b1, "R8 promisc accepts");
    doCheck(48'h1234_5678_9ABC, 1'b0, 1'b0, "R8 promisc off rejects");
  endtask

  task automatic testLoadB();
    sendSetup(tblB, 48, 1'b1, "R3 load B");
    doCheck(tblB[0], 1'b0, 1'b1, "R3 new table");
    doCheck(tblB[13], 1'b0, 1'b1, "R6 entry match B");
    doCheck(tblA[0], 1'b0, 1'b0, "R3 old entries gone");
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int e = 0; e < 15; e++) begin
      tblA[e] = genAddr(1, e);
      tblB[e] = genAddr(2, e);
    end
    tblA[15] = 48'hFFFF_FFFF_FFFF;
    tblB[15] = genAddr(2, 15);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadA();
    testShort();
    testLong();
    testPromisc();
    testLoadB();
    finishRun();
  end
endmodule